// File: doc/BRIEF.md
# Columnar String Column Reader

This block fetches one variable-length string column from memory and hands it to a compute kernel as two independent streams. The column is stored as three contiguous regions: a table of 32-bit signed offsets (one more entry than rows), a packed byte region holding the characters of every row back to back, and an optional validity bitmap. Software issues a command naming a half-open row range and the three base addresses. The block then fetches the bitmap and the offsets into local tables. Afterwards it streams one length entry per row and the row characters, packed several per cycle.

Since rows are located through offsets rather than stored lengths, a command may start at any row without touching earlier rows. All memory traffic is issued as bursts on a simple in-order read port. Each non-empty valid row is fetched as one burst covering the word-aligned span of its characters. A single done pulse marks the end of each command.

Top module: `strcol_reader`

## Requirements
- R1: `cmd_ready` is high only while the block is idle; a command is taken when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` stays low until the command completes.
- R2: Memory requests, with byte addresses and word counts, come in this order. First the bitmap burst if one is needed (see R4). Next one offsets burst of (last-first+1) words at `off_base + 4*first`. Then, for each valid row of nonzero length in row order, one burst at the word-aligned address of `val_base + offset[row]` covering ceil(((that address mod 4) + length)/4) words.
- R3: The length stream carries exactly one entry per row in the range, in row order; for a valid row the length equals offset[row+1] - offset[row].
- R4: When `cmd_nullable` is 1, row r is null when bit (r mod 8) of bitmap byte (r div 8) is 0, bits counted from the least significant. The bitmap is fetched as one burst of whole 32-bit words from `bmp_base + 4*(first div 32)`. A null row is reported with `len_null`=1 and length 0 and produces no character beats, whatever its offsets span. When `cmd_nullable` is 0 no bitmap is fetched and every row is valid.
- R5: The character stream carries each valid row's bytes in address order from `val_base + offset[row]`, byte k of a beat in bits [8k+7:8k]. `chr_count` gives the number of valid lanes (1 to LANES), every beat of a row except its final one is full, and unused lanes are zero.
- R6: `chr_last` is 1 on exactly the final beat of each row; a row of length zero emits no beat.
- R7: While any output stream (`len_*`, `chr_*`, `mem_req_*`) holds valid high and its ready low, its valid and payload stay unchanged in the next cycle.
- R8: `done` is high for exactly one cycle once the final length entry and the final character beat of a command have been accepted, after which `cmd_ready` is high; a command with first equal to last produces only the offsets fetch and the done pulse.
- R9: Out of reset `cmd_ready` is 1 and `done`, `len_valid`, `chr_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and taking a command |
| cmd_first | input | 32 | First row index |
| cmd_last | input | 32 | Row index one past the final row |
| cmd_off_base | input | ADDR_W | Byte address of the offsets table (4-byte aligned) |
| cmd_val_base | input | ADDR_W | Byte address of the character region |
| cmd_bmp_base | input | ADDR_W | Byte address of the validity bitmap (4-byte aligned) |
| cmd_nullable | input | 1 | 1 when the bitmap is to be used |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request taken |
| mem_req_addr | output | ADDR_W | Word-aligned byte address of the burst |
| mem_req_beats | output | BEAT_W | Number of 32-bit words in the burst |
| mem_rsp_valid | input | 1 | Response word valid (in request order) |
| mem_rsp_ready | output | 1 | Response word taken |
| mem_rsp_data | input | 32 | Response word, lowest address in bits [7:0] |
| len_valid | output | 1 | Length entry valid |
| len_ready | input | 1 | Length entry taken |
| len_length | output | 32 | Row length in bytes |
| len_null | output | 1 | Row is null |
| chr_valid | output | 1 | Character beat valid |
| chr_ready | input | 1 | Character beat taken |
| chr_data | output | 8*LANES | Character lanes |
| chr_count | output | $clog2(LANES+1) | Number of valid lanes |
| chr_last | output | 1 | Final beat of the row |

## Verification
The hardest case to reach is a character beat that must hold still under backpressure while the packing buffer is still being filled. That is a row start that is not word aligned, longer than one beat, with memory responses arriving while the kernel stalls. The bench reaches it by building offset tables whose first offset is odd and whose rows are up to eleven bytes long, then running them with pseudo-random ready and valid gaps on all ports. A null row whose offsets still span bytes, and a row range that straddles a 32-bit bitmap word, show that skipped bytes and bits are neither fetched nor emitted.

// File: rtl/strcol_pkg.sv
package strcol_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VREQ,
        ST_VDAT,
        ST_OREQ,
        ST_ODAT,
        ST_RUN
    } ctl_state_e;

    typedef enum logic [1:0] {
        CE_PICK,
        CE_REQ,
        CE_STREAM
    } fetch_state_e;

    // Number of 32-bit words covering nbytes that start at byte lane lead.
    function automatic logic [31:0] word_span(input logic [1:0] lead, input logic [31:0] nbytes);
        return (32'(lead) + nbytes + 32'd3) >> 2;
    endfunction

endpackage

// File: rtl/strcol_len_emit.sv
module strcol_len_emit #(
    parameter int ROW_IW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic [ROW_IW-1:0] nrows,
    input  logic [31:0]       row_lo,
    input  logic [31:0]       row_hi,
    input  logic              row_ok,
    output logic [ROW_IW-1:0] idx,
    output logic              len_valid,
    input  logic              len_ready,
    output logic [31:0]       len_length,
    output logic              len_null,
    output logic              fin
);

    logic [ROW_IW-1:0] idx_q;

    assign idx        = idx_q;
    assign fin        = (idx_q == nrows);
    assign len_valid  = run && (idx_q != nrows);
    assign len_null   = !row_ok;
    assign len_length = row_ok ? (row_hi - row_lo) : 32'd0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
        end else if (len_valid && len_ready) begin
            idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/strcol_char_fetch.sv
module strcol_char_fetch
    import strcol_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 16,
    parameter int ROW_IW = 5,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               run,
    input  logic [ROW_IW-1:0]  nrows,
    input  logic [ADDR_W-1:0]  val_base,
    input  logic [31:0]        row_lo,
    input  logic [31:0]        row_hi,
    input  logic               row_ok,
    output logic [ROW_IW-1:0]  idx,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [BEAT_W-1:0]  req_beats,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [31:0]        rsp_data,
    output logic               chr_valid,
    input  logic               chr_ready,
    output logic [8*LANES-1:0] chr_data,
    output logic [CNT_W-1:0]   chr_count,
    output logic               chr_last,
    output logic               fin
);

    localparam int STG   = LANES + WORD_BYTES;
    localparam int STG_W = $clog2(STG + 1);

    fetch_state_e      st_q;
    logic [ROW_IW-1:0] idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] beats_q;
    logic [1:0]        lane0_q;
    logic              head_q;
    logic [31:0]       rem_q;
    logic [7:0]        stg_q [STG];
    logic [STG_W-1:0]  cnt_q;

    logic [7:0]        stg_d [STG];
    logic [STG_W-1:0]  cnt_d;
    logic [31:0]       rem_d;
    logic [STG_W-1:0]  npop;
    logic [STG_W-1:0]  cnt_a;
    logic [1:0]        skip;
    logic [31:0]       avail;
    logic [31:0]       take_n;
    logic              take;
    logic [31:0]       row_len;
    logic [ADDR_W-1:0] row_addr;

    assign idx       = idx_q;
    assign fin       = (st_q == CE_PICK) && (idx_q == nrows);
    assign req_valid = (st_q == CE_REQ);
    assign req_addr  = addr_q;
    assign req_beats = beats_q;
    assign row_len   = row_hi - row_lo;
    assign row_addr  = val_base + ADDR_W'(row_lo);

    // Output beat: lanes come straight from the staging registers.
    always_comb begin
        chr_valid = (st_q == CE_STREAM) &&
                    ((cnt_q >= STG_W'(LANES)) || (rem_q == 32'd0 && cnt_q != '0));
        chr_count = (cnt_q >= STG_W'(LANES)) ? CNT_W'(LANES) : CNT_W'(cnt_q);
        chr_last  = (rem_q == 32'd0) && (cnt_q <= STG_W'(LANES));
        for (int j = 0; j < LANES; j++) begin
            chr_data[8*j +: 8] = (STG_W'(j) < cnt_q) ? stg_q[j] : 8'h00;
        end
    end

    // Staging buffer: pop the leading lanes, then append the useful bytes of a word.
    always_comb begin
        npop      = (chr_valid && chr_ready) ? STG_W'(chr_count) : '0;
        cnt_a     = cnt_q - npop;
        rsp_ready = (st_q == CE_STREAM) && (rem_q != 32'd0) && (cnt_a <= STG_W'(LANES));
        take      = rsp_valid && rsp_ready;
        skip      = head_q ? lane0_q : 2'd0;
        avail     = 32'd4 - 32'(skip);
        take_n    = (rem_q < avail) ? rem_q : avail;
        for (int j = 0; j < STG; j++) begin
            if (j + int'(npop) < STG) begin
                stg_d[j] = stg_q[j + int'(npop)];
            end else begin
                stg_d[j] = 8'h00;
            end
        end
        if (take) begin
            for (int j = 0; j < STG; j++) begin
                if (j >= int'(cnt_a) && j < int'(cnt_a) + int'(take_n)) begin
                    stg_d[j] = rsp_data[8*((j - int'(cnt_a) + int'(skip)) % 4) +: 8];
                end
            end
        end
        cnt_d = cnt_a + (take ? STG_W'(take_n) : '0);
        rem_d = take ? (rem_q - take_n) : rem_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CE_PICK;
            idx_q   <= '0;
            addr_q  <= '0;
            beats_q <= '0;
            lane0_q <= '0;
            head_q  <= 1'b0;
            rem_q   <= '0;
            cnt_q   <= '0;
            for (int j = 0; j < STG; j++) stg_q[j] <= 8'h00;
        end else if (clr) begin
            st_q  <= CE_PICK;
            idx_q <= '0;
            cnt_q <= '0;
            rem_q <= '0;
        end else begin
            case (st_q)
                CE_PICK: begin
                    if (run && idx_q != nrows) begin
                        if (!row_ok || $signed(row_len) <= 0) begin
                            idx_q <= idx_q + 1'b1;
                        end else begin
                            addr_q  <= {row_addr[ADDR_W-1:2], 2'b00};
                            lane0_q <= row_addr[1:0];
                            beats_q <= BEAT_W'(word_span(row_addr[1:0], row_len));
                            rem_q   <= row_len;
                            st_q    <= CE_REQ;
                        end
                    end
                end
                CE_REQ: begin
                    if (req_ready) begin
                        st_q   <= CE_STREAM;
                        head_q <= 1'b1;
                    end
                end
                CE_STREAM: begin
                    stg_q <= stg_d;
                    cnt_q <= cnt_d;
                    rem_q <= rem_d;
                    if (take) head_q <= 1'b0;
                    if (rem_d == 32'd0 && cnt_d == '0) begin
                        st_q  <= CE_PICK;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= CE_PICK;
            endcase
        end
    end

endmodule

// File: rtl/strcol_reader.sv
module strcol_reader
    import strcol_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_ROWS = 16,
    parameter int ADDR_W   = 32,
    parameter int BEAT_W   = 16,
    localparam int CNT_W   = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [31:0]        cmd_first,
    input  logic [31:0]        cmd_last,
    input  logic [ADDR_W-1:0]  cmd_off_base,
    input  logic [ADDR_W-1:0]  cmd_val_base,
    input  logic [ADDR_W-1:0]  cmd_bmp_base,
    input  logic               cmd_nullable,
    output logic               done,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [BEAT_W-1:0]  mem_req_beats,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [31:0]        mem_rsp_data,
    output logic               len_valid,
    input  logic               len_ready,
    output logic [31:0]        len_length,
    output logic               len_null,
    output logic               chr_valid,
    input  logic               chr_ready,
    output logic [8*LANES-1:0] chr_data,
    output logic [CNT_W-1:0]   chr_count,
    output logic               chr_last
);

    localparam int ROW_IW = $clog2(MAX_ROWS + 2);
    localparam int NV     = MAX_ROWS / 32 + 2;
    localparam int VI_W   = $clog2(NV);

    ctl_state_e        st_q;
    logic [31:0]       first_q;
    logic [31:0]       last_q;
    logic [ROW_IW-1:0] nrows_q;
    logic [ADDR_W-1:0] off_base_q;
    logic [ADDR_W-1:0] val_base_q;
    logic [ADDR_W-1:0] bmp_base_q;
    logic              nullable_q;
    logic [ROW_IW-1:0] ld_cnt_q;
    logic [31:0]       offs   [MAX_ROWS+1];
    logic [31:0]       vwords [NV];

    logic [31:0]       vw_last;
    logic              clr;
    logic              run;
    logic              len_fin;
    logic              chr_fin;
    logic [ROW_IW-1:0] len_idx;
    logic [ROW_IW-1:0] chr_idx;
    logic              ce_req_valid;
    logic [ADDR_W-1:0] ce_req_addr;
    logic [BEAT_W-1:0] ce_req_beats;
    logic              ce_rsp_ready;

    assign cmd_ready = (st_q == ST_IDLE);
    assign clr       = cmd_ready && cmd_valid;
    assign run       = (st_q == ST_RUN);
    assign done      = run && len_fin && chr_fin;
    assign vw_last   = ((last_q - 32'd1) >> 5) - (first_q >> 5);

    // Two read ports into the offset and validity tables: 0 for lengths, 1 for characters.
    for (genvar p = 0; p < 2; p++) begin : g_look
        logic [ROW_IW-1:0] ridx;
        logic [31:0]       abs_row;
        logic [31:0]       wsel;
        logic [31:0]       lo;
        logic [31:0]       hi;
        logic              ok;
        assign ridx = (p == 0) ? len_idx : chr_idx;
        always_comb begin
            abs_row = first_q + 32'(ridx);
            wsel    = (abs_row >> 5) - (first_q >> 5);
            lo      = offs[ridx];
            hi      = offs[ROW_IW'(ridx + 1'b1)];
            ok      = !nullable_q || vwords[wsel[VI_W-1:0]][abs_row[4:0]];
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        mem_req_beats = '0;
        mem_rsp_ready = 1'b0;
        case (st_q)
            ST_VREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = bmp_base_q + ADDR_W'((first_q >> 5) << 2);
                mem_req_beats = BEAT_W'(vw_last + 32'd1);
            end
            ST_OREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = off_base_q + ADDR_W'(first_q << 2);
                mem_req_beats = BEAT_W'(32'(nrows_q) + 32'd1);
            end
            ST_VDAT, ST_ODAT: mem_rsp_ready = 1'b1;
            ST_RUN: begin
                mem_req_valid = ce_req_valid;
                mem_req_addr  = ce_req_addr;
                mem_req_beats = ce_req_beats;
                mem_rsp_ready = ce_rsp_ready;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            first_q    <= '0;
            last_q     <= '0;
            nrows_q    <= '0;
            off_base_q <= '0;
            val_base_q <= '0;
            bmp_base_q <= '0;
            nullable_q <= 1'b0;
            ld_cnt_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        first_q    <= cmd_first;
                        last_q     <= cmd_last;
                        nrows_q    <= ROW_IW'(cmd_last - cmd_first);
                        off_base_q <= cmd_off_base;
                        val_base_q <= cmd_val_base;
                        bmp_base_q <= cmd_bmp_base;
                        nullable_q <= cmd_nullable;
                        st_q <= (cmd_nullable && cmd_last != cmd_first) ? ST_VREQ : ST_OREQ;
                    end
                end
                ST_VREQ: begin
                    if (mem_req_ready) begin
                        st_q     <= ST_VDAT;
                        ld_cnt_q <= '0;
                    end
                end
                ST_VDAT: begin
                    if (mem_rsp_valid) begin
                        ld_cnt_q <= ld_cnt_q + 1'b1;
                        if (ld_cnt_q == ROW_IW'(vw_last)) st_q <= ST_OREQ;
                    end
                end
                ST_OREQ: begin
                    if (mem_req_ready) begin
                        st_q     <= ST_ODAT;
                        ld_cnt_q <= '0;
                    end
                end
                ST_ODAT: begin
                    if (mem_rsp_valid) begin
                        ld_cnt_q <= ld_cnt_q + 1'b1;
                        if (ld_cnt_q == nrows_q) st_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (len_fin && chr_fin) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Table capture, no reset needed: every entry read is written first.
    always_ff @(posedge clk) begin
        if (st_q == ST_VDAT && mem_rsp_valid) vwords[ld_cnt_q[VI_W-1:0]] <= mem_rsp_data;
        if (st_q == ST_ODAT && mem_rsp_valid) offs[ld_cnt_q] <= mem_rsp_data;
    end

    strcol_len_emit #(
        .ROW_IW (ROW_IW)
    ) u_len (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .run        (run),
        .nrows      (nrows_q),
        .row_lo     (g_look[0].lo),
        .row_hi     (g_look[0].hi),
        .row_ok     (g_look[0].ok),
        .idx        (len_idx),
        .len_valid  (len_valid),
        .len_ready  (len_ready),
        .len_length (len_length),
        .len_null   (len_null),
        .fin        (len_fin)
    );

    strcol_char_fetch #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W),
        .ROW_IW (ROW_IW)
    ) u_chr (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .run       (run),
        .nrows     (nrows_q),
        .val_base  (val_base_q),
        .row_lo    (g_look[1].lo),
        .row_hi    (g_look[1].hi),
        .row_ok    (g_look[1].ok),
        .idx       (chr_idx),
        .req_valid (ce_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (ce_req_addr),
        .req_beats (ce_req_beats),
        .rsp_valid (mem_rsp_valid),
        .rsp_ready (ce_rsp_ready),
        .rsp_data  (mem_rsp_data),
        .chr_valid (chr_valid),
        .chr_ready (chr_ready),
        .chr_data  (chr_data),
        .chr_count (chr_count),
        .chr_last  (chr_last),
        .fin       (chr_fin)
    );

endmodule

// File: rtl/strcol_reader_chk.sv
module strcol_reader_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 16,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               done,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [BEAT_W-1:0]  mem_req_beats,
    input logic               len_valid,
    input logic               len_ready,
    input logic [31:0]        len_length,
    input logic               len_null,
    input logic               chr_valid,
    input logic               chr_ready,
    input logic [8*LANES-1:0] chr_data,
    input logic [CNT_W-1:0]   chr_count,
    input logic               chr_last
);

    a_r1_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    a_r4_null_has_no_length: assert property (@(posedge clk) disable iff (rst)
        len_valid && len_null |-> len_length == 32'd0);

    a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
        chr_valid |-> (chr_count != '0) && (chr_count <= CNT_W'(LANES)));

    a_r5_inner_beats_full: assert property (@(posedge clk) disable iff (rst)
        chr_valid && !chr_last |-> chr_count == CNT_W'(LANES));

    a_r7_len_hold: assert property (@(posedge clk) disable iff (rst)
        len_valid && !len_ready |=> len_valid && $stable(len_length) && $stable(len_null));

    a_r7_chr_hold: assert property (@(posedge clk) disable iff (rst)
        chr_valid && !chr_ready |=> chr_valid && $stable(chr_data) && $stable(chr_count)
                                    && $stable(chr_last));

    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_beats));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> cmd_ready);

endmodule

bind strcol_reader strcol_reader_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (.*);

// File: tb/sim_strcol_reader.sv
module sim_strcol_reader;

    localparam int LANES    = 4;
    localparam int CNT_W    = $clog2(LANES + 1);
    localparam int BMP_BASE = 32'h040;
    localparam int OFF_BASE = 32'h100;
    localparam int VAL_BASE = 32'h300;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [31:0]        cmd_first = '0;
    logic [31:0]        cmd_last = '0;
    logic [31:0]        cmd_off_base = '0;
    logic [31:0]        cmd_val_base = '0;
    logic [31:0]        cmd_bmp_base = '0;
    logic               cmd_nullable = 1'b0;
    logic               done;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b0;
    logic [31:0]        mem_req_addr;
    logic [15:0]        mem_req_beats;
    logic               mem_rsp_valid = 1'b0;
    logic               mem_rsp_ready;
    logic [31:0]        mem_rsp_data = '0;
    logic               len_valid;
    logic               len_ready = 1'b0;
    logic [31:0]        len_length;
    logic               len_null;
    logic               chr_valid;
    logic               chr_ready = 1'b0;
    logic [8*LANES-1:0] chr_data;
    logic [CNT_W-1:0]   chr_count;
    logic               chr_last;

    always #10 clk = ~clk;

    strcol_reader #(.LANES(LANES), .MAX_ROWS(16), .ADDR_W(32), .BEAT_W(16)) u0 (.*);

    logic [7:0]  mem [2048];
    int          checks = 0;
    int          errors = 0;
    bit          stall = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          burst_left = 0;
    int          burst_addr = 0;
    int          req_addr_log [32];
    int          req_beat_log [32];
    int          nreq = 0;
    int          ln_len [64];
    bit          ln_null [64];
    int          nlen = 0;
    int          bt_cnt [256];
    bit          bt_last [256];
    logic [31:0] bt_data [256];
    int          nbeat = 0;
    int          ndone = 0;
    int          lens [64];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rd_word(input int a);
        return {mem[(a+3)&2047], mem[(a+2)&2047], mem[(a+1)&2047], mem[a&2047]};
    endfunction

    function automatic int off_of(input int row);
        return rd_word(OFF_BASE + 4*row);
    endfunction

    function automatic bit valid_of(input int row, input bit nullable);
        return !nullable || mem[BMP_BASE + row/8][row%8];
    endfunction

    // Memory model and stream sinks: drive at the falling edge, record handshakes after settle.
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = (burst_left == 0) && (!stall || lfsr[2]);
            mem_rsp_valid = (burst_left > 0) && (!stall || lfsr[3]);
            mem_rsp_data  = rd_word(burst_addr);
            len_ready     = !stall || lfsr[0];
            chr_ready     = !stall || lfsr[1] || lfsr[5];
            #1;
            if (mem_rsp_valid && mem_rsp_ready) begin
                burst_addr += 4;
                burst_left--;
            end
            if (mem_req_valid && mem_req_ready) begin
                burst_addr = int'(mem_req_addr);
                burst_left = int'(mem_req_beats);
                if (nreq < 32) begin
                    req_addr_log[nreq] = int'(mem_req_addr);
                    req_beat_log[nreq] = int'(mem_req_beats);
                end
                nreq++;
            end
            if (len_valid && len_ready) begin
                if (nlen < 64) begin
                    ln_len[nlen]  = int'(len_length);
                    ln_null[nlen] = len_null;
                end
                nlen++;
            end
            if (chr_valid && chr_ready) begin
                if (nbeat < 256) begin
                    bt_cnt[nbeat]  = int'(chr_count);
                    bt_last[nbeat] = chr_last;
                    bt_data[nbeat] = chr_data;
                end
                nbeat++;
            end
            if (done) ndone++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Offsets table for rows 0..total-1 built from lens[], starting at start_off.
    task automatic build_table(input int total, input int start_off);
        int o = start_off;
        for (int r = 0; r <= total; r++) begin
            for (int b = 0; b < 4; b++) mem[OFF_BASE + 4*r + b] = 8'(o >> (8*b));
            if (r < total) o += lens[r];
        end
    endtask

    task automatic run_cmd(input int first, input int last, input bit nullable);
        nreq = 0; nlen = 0; nbeat = 0; ndone = 0;
        @(negedge clk);
        cmd_first = first; cmd_last = last; cmd_nullable = nullable;
        cmd_off_base = OFF_BASE; cmd_val_base = VAL_BASE; cmd_bmp_base = BMP_BASE;
        cmd_valid = 1'b1;
        #2;
        while (!cmd_ready) begin
            @(negedge clk);
            #2;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int t = 0; t < 5000 && ndone == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Compare every log against values derived from memory contents and the requirements.
    task automatic check_run(input int first, input int last, input bit nullable);
        int n = last - first;
        int q = 0;
        int b = 0;
        chk(ndone == 1, "R8", "done pulses", ndone, 1);
        chk(nlen == n, "R3", "length entries", nlen, n);
        if (nullable && n > 0) begin
            chk(req_addr_log[q] == BMP_BASE + 4*(first/32), "R4", "bitmap addr", req_addr_log[q], BMP_BASE + 4*(first/32));
            chk(req_beat_log[q] == (last-1)/32 - first/32 + 1, "R4", "bitmap beats", req_beat_log[q], (last-1)/32 - first/32 + 1);
            q++;
        end
        chk(req_addr_log[q] == OFF_BASE + 4*first, "R2", "offsets addr", req_addr_log[q], OFF_BASE + 4*first);
        chk(req_beat_log[q] == n + 1, "R2", "offsets beats", req_beat_log[q], n + 1);
        q++;
        for (int i = 0; i < n; i++) begin
            int row = first + i;
            int len = off_of(row + 1) - off_of(row);
            bit ok = valid_of(row, nullable);
            int start = VAL_BASE + off_of(row);
            if (i < nlen) begin
                if (ok) chk(ln_len[i] == len && !ln_null[i], "R3", "row length", ln_len[i], len);
                else    chk(ln_len[i] == 0 && ln_null[i], "R4", "null row entry", ln_len[i] + 1000*ln_null[i], 1000);
            end
            if (ok && len > 0) begin
                int ebeats = ((start % 4) + len + 3) / 4;
                chk(req_addr_log[q] == (start & ~3), "R2", "row burst addr", req_addr_log[q], start & ~3);
                chk(req_beat_log[q] == ebeats, "R2", "row burst beats", req_beat_log[q], ebeats);
                q++;
                for (int pos = 0; pos < len; pos += LANES) begin
                    int cnt = (len - pos < LANES) ? len - pos : LANES;
                    bit lst = (pos + LANES >= len);
                    logic [31:0] ed = '0;
                    for (int j = 0; j < cnt; j++) ed[8*j +: 8] = mem[start + pos + j];
                    if (b < nbeat) begin
                        chk(bt_cnt[b] == cnt, "R5", "beat count", bt_cnt[b], cnt);
                        chk(bt_data[b] == ed, "R5", "beat data", int'(bt_data[b]), int'(ed));
                        chk(bt_last[b] == lst, "R6", "beat last", int'(bt_last[b]), int'(lst));
                    end
                    b++;
                end
            end
        end
        chk(nbeat == b, "R6", "total char beats", nbeat, b);
        chk(nreq == q, "R2", "request count", nreq, q);
        chk(cmd_ready == 1'b1, "R8", "idle after done", int'(cmd_ready), 1);
    endtask

    task automatic t_reset();
        #1;
        chk(cmd_ready == 1'b1, "R9", "cmd_ready", int'(cmd_ready), 1);
        chk(!done && !len_valid && !chr_valid && !mem_req_valid, "R9", "outputs idle",
            int'({done, len_valid, chr_valid, mem_req_valid}), 0);
    endtask

    // Three rows 3,3,4 from offset 0; bitmap all zero but unused (R4 ignored when not nullable).
    task automatic t_basic();
        stall = 0;
        lens[0] = 3; lens[1] = 3; lens[2] = 4;
        build_table(3, 0);
        for (int k = 0; k < 8; k++) mem[BMP_BASE + k] = 8'h00;
        run_cmd(0, 3, 1'b0);
        check_run(0, 3, 1'b0);
        chk(ln_len[2] == 4, "R3", "basic third row", ln_len[2], 4);
    endtask

    // Mid-table start, odd first offset, zero-length row, null row with nonzero span, stalls.
    task automatic t_mid();
        stall = 1;
        lens[0] = 2; lens[1] = 7; lens[2] = 0; lens[3] = 5; lens[4] = 1;
        lens[5] = 11; lens[6] = 3; lens[7] = 9; lens[8] = 4; lens[9] = 6;
        build_table(10, 5);
        mem[BMP_BASE] = 8'b1010_1111;
        mem[BMP_BASE + 1] = 8'hFF;
        run_cmd(2, 9, 1'b1);
        check_run(2, 9, 1'b1);
        chk(ln_null[2] == 1'b1, "R4", "row 4 flagged null", int'(ln_null[2]), 1);
    endtask

    task automatic t_empty();
        stall = 0;
        run_cmd(3, 3, 1'b1);
        check_run(3, 3, 1'b1);
        chk(nbeat == 0 && nlen == 0, "R8", "empty range output", nbeat + nlen, 0);
    endtask

    // Range straddling two 32-bit bitmap words.
    task automatic t_bitmap_wrap();
        stall = 1;
        for (int r = 0; r < 40; r++) lens[r] = (r * 5) % 9;
        build_table(40, 1);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            for (int bi = 0; bi < 8; bi++) v[bi] = ((8*k + bi) % 3) != 1;
            mem[BMP_BASE + k] = v;
        end
        run_cmd(28, 37, 1'b1);
        check_run(28, 37, 1'b1);
    endtask

    initial begin
        for (int k = 0; k < 2048; k++) mem[k] = 8'(k * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_mid();
        t_empty();
        t_bitmap_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule